// File: doc/BRIEF.md
# Single-Cycle Register Calculator Core

This block is a minimal processor that finishes one instruction in every clock cycle. It has a program counter, a 32-word internal instruction store, sixteen 16-bit registers and an arithmetic/logic unit with eight operation codes. On each rising edge it reads the word the program counter points at, works out a result from a first register and a second operand, writes that result into a destination register and moves the counter on. A type bit picks the second operand: either another register or a sign-extended 16-bit constant taken from the instruction word.

Operation code 7 handles control flow. In its constant form it is a call: it saves the address of the next instruction in register 15 and jumps by a signed offset. In its register form it is a return: it loads the counter from register 15. Subtraction goes through the same adder as addition. The second operand is inverted and the carry-in is forced high. The testbench loads the instruction store. A read-only port shows the contents of any register.

Top module: `calc_core`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter and all registers, so after reset `pc_o` = 0 and every register reads 0.
- R2: When instruction bit 31 is 1 (register form), the result is D = S op T, with S in bits [27:24], T in bits [23:20] and D in bits [19:16]. Bits [15:0] have no effect.
- R3: When bit 31 is 0 (constant form), the second operand is bits [15:0] sign-extended to 16 bits, and the T field has no effect.
- R4: The operation in bits [30:28] is: 0 add, 1 subtract (S minus operand, computed as S + ~B + 1), 2 AND, 3 OR, 4 XOR, 5 bitwise NOT of S, 6 pass the second operand.
- R5: Every non-control instruction writes back in the same cycle it executes, and the program counter advances by one, wrapping at the store depth.
- R6: Operation 7 with bit 31 = 0 (call) writes the counter plus one into register 15 and sets the counter to counter + sign-extended bits [15:0], both on the same edge.
- R7: Operation 7 with bit 31 = 1 (return) loads the counter from register 15 and writes no register.
- R8: Register 0 always reads as zero. Writes to it have no effect.
- R9: `dbg_val` shows, combinationally, the register chosen by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 4 | Register index to observe |
| dbg_val | output | 16 | Contents of the observed register |
| pc_o | output | 5 | Current program counter |

## Verification
A call does two things on the same edge: it writes the link register and redirects the counter. The bench runs calls with both a forward and a backward offset. After each call edge it checks the new counter and the contents of register 15 together. It also puts a return right after an instruction that overwrites register 15, and right after a call. In each case the jump target must be the value written one cycle earlier.

// File: rtl/calc_core.sv
module calc_core #(
  parameter int DW = 16,
  parameter int IMEM_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [3:0]                    dbg_sel,
  output logic [DW-1:0]                 dbg_val,
  output logic [$clog2(IMEM_DEPTH)-1:0] pc_o
);
  localparam int PW = $clog2(IMEM_DEPTH);
  localparam int NREG = 16;
  localparam logic [3:0] LINK = 4'd15;

  logic [31:0]   imem [IMEM_DEPTH];
  logic [DW-1:0] rf [NREG];
  logic [PW-1:0] pc;

  initial begin
    for (int i = 0; i < IMEM_DEPTH; i++) imem[i] = '0;
  end

  logic [31:0] instr;
  logic        typ, is_ctl, is_call, is_ret, is_sub;
  logic [2:0]  op;
  logic [3:0]  rs, rt, rd;
  logic [15:0] imm;

  assign instr = imem[pc];
  assign typ   = instr[31];
  assign op    = instr[30:28];
  assign rs    = instr[27:24];
  assign rt    = instr[23:20];
  assign rd    = instr[19:16];
  assign imm   = instr[15:0];

  assign is_ctl  = (op == 3'd7);
  assign is_call = is_ctl & ~typ;
  assign is_ret  = is_ctl & typ;
  assign is_sub  = (op == 3'd1);

  logic [DW-1:0] opa, opb, imm_x, b_in, sum, res;

  assign imm_x = DW'($signed(imm));
  assign opa   = (rs == 4'd0) ? '0 : rf[rs];
  assign opb   = typ ? ((rt == 4'd0) ? '0 : rf[rt]) : imm_x;
  assign b_in  = is_sub ? ~opb : opb;
  assign sum   = opa + b_in + DW'(is_sub);

  always_comb begin
    case (op)
      3'd0, 3'd1: res = sum;
      3'd2:       res = opa & opb;
      3'd3:       res = opa | opb;
      3'd4:       res = opa ^ opb;
      3'd5:       res = ~opa;
      3'd6:       res = opb;
      default:    res = '0;
    endcase
  end

  logic [PW-1:0] pc_inc, pc_jmp;
  assign pc_inc = pc + 1'b1;
  assign pc_jmp = pc + PW'(imm);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (is_ret)       pc <= PW'(rf[LINK]);
      else if (is_call) pc <= pc_jmp;
      else              pc <= pc_inc;
      if (is_call)                      rf[LINK] <= DW'(pc_inc);
      else if (!is_ctl && rd != 4'd0)   rf[rd]   <= res;
    end
  end

  assign dbg_val = (dbg_sel == 4'd0) ? '0 : rf[dbg_sel];
  assign pc_o    = pc;
endmodule

// File: rtl/calc_core_chk.sv
module calc_core_chk #(
  parameter int DW = 16,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [PW-1:0] pc,
  input logic [31:0]   instr,
  input logic [DW-1:0] link_q,
  input logic [DW-1:0] opa,
  input logic [DW-1:0] opb,
  input logic [DW-1:0] res,
  input logic [3:0]    dbg_sel,
  input logic [DW-1:0] dbg_val
);
  logic ctl;
  assign ctl = (instr[30:28] == 3'd7);

  a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
    (dbg_sel == 4'd0) |-> (dbg_val == '0));

  a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
    !ctl |=> (pc == $past(pc) + 1'b1));

  a_r6_call_link: assert property (@(posedge clk) disable iff (rst)
    (ctl && !instr[31]) |=> (link_q == DW'($past(pc) + 1'b1)) &&
                             (pc == $past(pc) + PW'($past(instr[15:0]))));

  a_r7_ret_target: assert property (@(posedge clk) disable iff (rst)
    (ctl && instr[31]) |=> (pc == PW'($past(link_q))));

  a_r4_sub_diff: assert property (@(posedge clk) disable iff (rst)
    (instr[30:28] == 3'd1) |-> (res == opa - opb));

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> (pc == '0));
endmodule

bind calc_core calc_core_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .pc(pc), .instr(instr), .link_q(rf[15]),
  .opa(opa), .opb(opb), .res(res), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
);

// File: tb/calc_core_tb.sv
module calc_core_tb;
  localparam int DW = 16;
  localparam int DEPTH = 32;
  localparam int PW = 5;
  localparam int N = 23;

  logic          clk = 0;
  logic          rst = 1;
  logic [3:0]    dbg_sel = 0;
  logic [DW-1:0] dbg_val;
  logic [PW-1:0] pc_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  calc_core #(.DW(DW), .IMEM_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .dbg_sel(dbg_sel), .dbg_val(dbg_val), .pc_o(pc_o));

  function automatic logic [31:0] mk(input logic t, input logic [2:0] op,
      input logic [3:0] s, input logic [3:0] tt, input logic [3:0] d,
      input logic [15:0] imm);
    return {t, op, s, tt, d, imm};
  endfunction

  function automatic logic [67:0] ent(input logic [7:0] a, input logic [31:0] w,
      input logic [3:0] r, input logic [15:0] v, input logic [7:0] np);
    return {a, w, r, v, np};
  endfunction

  // {addr, instr, reg to check, expected value, expected next pc}, in execution order
  localparam logic [67:0] PROG [N] = '{
    ent(0,  mk(0,0,0,15,1,16'd5),     1,  16'h0005, 1),
    ent(1,  mk(0,0,0,0,2,16'hFFFD),   2,  16'hFFFD, 2),
    ent(2,  mk(1,0,1,2,3,0),          3,  16'h0002, 3),
    ent(3,  mk(1,1,1,2,4,0),          4,  16'h0008, 4),
    ent(4,  mk(1,1,2,1,5,0),          5,  16'hFFF8, 5),
    ent(5,  mk(1,2,1,2,6,0),          6,  16'h0005, 6),
    ent(6,  mk(0,3,1,0,7,16'h00F0),   7,  16'h00F5, 7),
    ent(7,  mk(1,4,2,1,8,0),          8,  16'hFFF8, 8),
    ent(8,  mk(1,5,1,0,9,0),          9,  16'hFFFA, 9),
    ent(9,  mk(1,6,0,3,10,0),         10, 16'h0002, 10),
    ent(10, mk(0,6,0,0,11,16'h7FFF),  11, 16'h7FFF, 11),
    ent(11, mk(1,0,1,1,0,0),          0,  16'h0000, 12),
    ent(12, mk(0,1,0,0,12,16'd1),     12, 16'hFFFF, 13),
    ent(13, mk(1,0,1,3,13,16'hABCD),  13, 16'h0007, 14),
    ent(14, mk(0,7,0,0,0,16'd5),      15, 16'h000F, 19),
    ent(19, mk(0,0,15,0,14,0),        14, 16'h000F, 20),
    ent(20, mk(1,7,0,0,0,0),          15, 16'h000F, 15),
    ent(15, mk(0,0,1,0,1,16'd1),      1,  16'h0006, 16),
    ent(16, mk(0,7,0,0,0,16'd10),     15, 16'h0011, 26),
    ent(26, mk(0,7,0,0,0,16'hFFFC),   15, 16'h001B, 22),
    ent(22, mk(1,7,0,0,0,0),          15, 16'h001B, 27),
    ent(27, mk(0,0,0,0,15,16'd3),     15, 16'h0003, 28),
    ent(28, mk(1,7,0,0,0,0),          15, 16'h0003, 3)
  };

  function automatic string tag(input logic [31:0] w);
    if (w[30:28] == 3'd7) return w[31] ? "R7" : "R6";
    if (w[19:16] == 4'd0) return "R8";
    return w[31] ? "R2/R4" : "R3/R4";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) u_dut.imem[PROG[i][67:60]] = PROG[i][59:28];
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc after reset", 32'(pc_o), 0);
    for (int r = 0; r < 16; r++) begin
      dbg_sel = 4'(r); #1;
      chk("R1/R9 register after reset", 32'(dbg_val), 0);
    end
    rst = 0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] w;
      w = PROG[i][59:28];
      dbg_sel = PROG[i][27:24];
      @(posedge clk);
      @(negedge clk);
      chk(tag(w), 32'(dbg_val), 32'(PROG[i][23:8]));
      chk("R5/R6/R7 next pc", 32'(pc_o), 32'(PROG[i][7:0]));
    end
    dbg_sel = 4'd1; #1;
    chk("R2 r1 kept", 32'(dbg_val), 16'h0006);
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 pc cleared mid-run", 32'(pc_o), 0);
    chk("R1 r1 cleared mid-run", 32'(dbg_val), 0);
    dbg_sel = 4'd15; #1;
    chk("R1 r15 cleared mid-run", 32'(dbg_val), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule